// File: doc/BRIEF.md
# Standby Power-Up Sequencer

This controller sits in an always-on standby domain. It brings the main supply rails of a system up in a fixed order after a local or remote start request. It leaves standby when the synchronized on-request line goes low. It then enables the rails one at a time: rail 0 (1V2), then rail 1 (2V5), then rail 2 (3V3). Each rail's enable is driven low only after the previous rail reports power-good.

After every rail is good, the sequencer waits a fixed settle time. It then releases the main system reset, and one cycle later it switches the display lamp on. From the moment any rail is enabled, the enabled rails and all protection lines are watched. A protection line going low, a power-good line dropping, or a rail that fails to report good within a programmable number of cycles sends the block into a latched fault state. In that state every enable returns to its safe high level, the system reset is held, the lamp is off and a fault flag is raised until the standby reset.

All asynchronous inputs pass through two-flop synchronizers before the state machine uses them.

Top module: `pwr_seq_top`

## Requirements
- R1: After rst_ni, every rail_en_no bit is 1, sys_rst_no is 0, lamp_on_o is 0 and fault_o is 0.
- R2: While on_req_ni stays 1 (and no protection is active), the block stays idle with all enables at 1.
- R3: Rails are enabled in index order 0, 1, 2 by driving rail_en_no[k] to 0. rail_en_no[k] for k>0 goes to 0 only after pgood_i[k-1] is 1, and an enabled rail stays enabled until a fault.
- R4: If a rail's pgood_i is not seen within wait_limit_i+1 cycles of waiting for it, the block faults, and no higher rail is ever enabled.
- R5: Once the last rail is good, at least SETTLE_CYC cycles pass before sys_rst_no goes to 1. sys_rst_no rises only while all rails are enabled.
- R6: lamp_on_o rises exactly one cycle after sys_rst_no rises, and lamp_on_o is never 1 while sys_rst_no is 0.
- R7: In the fault state, all rail_en_no bits are 1, sys_rst_no is 0, lamp_on_o is 0 and fault_o is 1.
- R8: Any prot_ni bit at 0, in any state, leads to the fault state.
- R9: A pgood_i bit of an enabled rail falling to 0 after it was seen good leads to the fault state.
- R10: fault_o stays 1 until rst_ni is asserted, whatever on_req_ni, prot_ni and pgood_i do.
- R11: Inputs are synchronized by two flops. A protection event driven before a clock edge shows on fault_o after the third rising edge and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Standby clock |
| rst_ni | input | 1 | Asynchronous active-low standby reset |
| on_req_ni | input | 1 | Power-on request, active low |
| prot_ni | input | N_PROT | Protection inputs, active low |
| pgood_i | input | N_RAILS | Rail power-good detect, 1 = good |
| wait_limit_i | input | TO_W | Power-good wait limit in cycles |
| rail_en_no | output | N_RAILS | Rail enables, active low |
| sys_rst_no | output | 1 | Main system reset, low holds reset |
| lamp_on_o | output | 1 | Display lamp on |
| fault_o | output | 1 | Latched fault flag |

## Verification
The hardest situations to reach are a power-good loss on a rail that is already up, and a timeout on a middle rail. Both need a supply whose response depends on what the block has already done. The bench therefore contains a small rail model. Each rail reports good a chosen number of cycles after its enable falls, can be set never to report good, and can be pulled low on demand. A vector table walks combinations of per-rail delays and wait limits against the expected outcome. Directed cases then inject protection and power-good drops while the sequencer is in its on state or is still sequencing.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RAIL    = 3'd1,
    ST_SETTLE  = 3'd2,
    ST_RELEASE = 3'd3,
    ST_ON      = 3'd4,
    ST_FAULT   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ff1_q, ff2_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff1_q[i] <= RST_VAL[i];
        ff2_q[i] <= RST_VAL[i];
      end else begin
        ff1_q[i] <= d_i[i];
        ff2_q[i] <= ff1_q[i];
      end
    end
  end

  assign q_o = ff2_q;
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] limit_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  assign hit_o = (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (en_i && !hit_o)  cnt_q <= cnt_q + 1'b1;
  end

  // R4: counter advances by exactly one while waiting
  a_r4_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !hit_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned N_RAILS = 3,
  parameter int unsigned N_PROT  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               on_req_ni,
  input  logic [N_PROT-1:0]  prot_ni,
  input  logic [N_RAILS-1:0] pgood_i,
  input  logic               tmr_hit_i,
  output logic               tmr_clr_o,
  output logic               tmr_en_o,
  output logic               tmr_settle_o,
  output logic [N_RAILS-1:0] rail_en_no,
  output logic               sys_rst_no,
  output logic               lamp_on_o,
  output logic               fault_o
);
  localparam int unsigned IDX_W = (N_RAILS > 1) ? $clog2(N_RAILS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_RAILS - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] rail_q, rail_d;
  logic             prot_bad, lower_bad, all_good;

  assign prot_bad = ~&prot_ni;
  assign all_good = &pgood_i;

  // rails already brought up must stay good
  always_comb begin
    lower_bad = 1'b0;
    for (int i = 0; i < N_RAILS; i++) begin
      if ((i < int'(rail_q)) && !pgood_i[i]) lower_bad = 1'b1;
    end
  end

  always_comb begin
    state_d   = state_q;
    rail_d    = rail_q;
    tmr_clr_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (prot_bad) state_d = ST_FAULT;
        else if (!on_req_ni) begin
          state_d   = ST_RAIL;
          rail_d    = '0;
          tmr_clr_o = 1'b1;
        end
      end
      ST_RAIL: begin
        if (prot_bad || lower_bad) state_d = ST_FAULT;
        else if (pgood_i[rail_q]) begin
          tmr_clr_o = 1'b1;
          if (rail_q == LAST_IDX) state_d = ST_SETTLE;
          else                    rail_d  = rail_q + 1'b1;
        end else if (tmr_hit_i) state_d = ST_FAULT;
      end
      ST_SETTLE: begin
        if (prot_bad || !all_good) state_d = ST_FAULT;
        else if (tmr_hit_i) begin
          state_d   = ST_RELEASE;
          tmr_clr_o = 1'b1;
        end
      end
      ST_RELEASE, ST_ON: begin
        if (prot_bad || !all_good) state_d = ST_FAULT;
        else                       state_d = ST_ON;
      end
      ST_FAULT: state_d = ST_FAULT;
      default:  state_d = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rail_q  <= '0;
    end else begin
      state_q <= state_d;
      rail_q  <= rail_d;
    end
  end

  always_comb begin
    for (int i = 0; i < N_RAILS; i++) begin
      rail_en_no[i] = !(((state_q == ST_RAIL) && (i <= int'(rail_q))) ||
                        (state_q == ST_SETTLE) || (state_q == ST_RELEASE) ||
                        (state_q == ST_ON));
    end
  end

  assign sys_rst_no   = (state_q == ST_RELEASE) || (state_q == ST_ON);
  assign lamp_on_o    = (state_q == ST_ON);
  assign fault_o      = (state_q == ST_FAULT);
  assign tmr_en_o     = (state_q == ST_RAIL) || (state_q == ST_SETTLE);
  assign tmr_settle_o = (state_q == ST_SETTLE);

  a_r8_prot_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_bad |=> (state_q == ST_FAULT));

  a_r9_pgood_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_ON) && !all_good) |=> (state_q == ST_FAULT));

  a_r10_fault_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FAULT) |=> (state_q == ST_FAULT));

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && on_req_ni && !prot_bad) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top #(
  parameter int unsigned N_RAILS    = 3,
  parameter int unsigned N_PROT     = 2,
  parameter int unsigned TO_W       = 16,
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               on_req_ni,
  input  logic [N_PROT-1:0]  prot_ni,
  input  logic [N_RAILS-1:0] pgood_i,
  input  logic [TO_W-1:0]    wait_limit_i,
  output logic [N_RAILS-1:0] rail_en_no,
  output logic               sys_rst_no,
  output logic               lamp_on_o,
  output logic               fault_o
);
  localparam int unsigned SW = 1 + N_PROT + N_RAILS;
  localparam logic [TO_W-1:0] SETTLE_LIM = TO_W'(SETTLE_CYC - 1);
  // on_req idle high, protections inactive high, power-good low
  localparam logic [SW-1:0] SYNC_RST = {1'b1, {N_PROT{1'b1}}, {N_RAILS{1'b0}}};

  logic [SW-1:0]      sync_q;
  logic               s_on_req_n;
  logic [N_PROT-1:0]  s_prot_n;
  logic [N_RAILS-1:0] s_pgood;
  logic               tmr_clr, tmr_en, tmr_settle, tmr_hit;
  logic [TO_W-1:0]    tmr_limit;

  pwr_seq_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({on_req_ni, prot_ni, pgood_i}),
    .q_o    (sync_q)
  );

  assign {s_on_req_n, s_prot_n, s_pgood} = sync_q;
  assign tmr_limit = tmr_settle ? SETTLE_LIM : wait_limit_i;

  pwr_seq_timer #(.W(TO_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tmr_clr),
    .en_i    (tmr_en),
    .limit_i (tmr_limit),
    .hit_o   (tmr_hit)
  );

  pwr_seq_fsm #(.N_RAILS(N_RAILS), .N_PROT(N_PROT)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .on_req_ni    (s_on_req_n),
    .prot_ni      (s_prot_n),
    .pgood_i      (s_pgood),
    .tmr_hit_i    (tmr_hit),
    .tmr_clr_o    (tmr_clr),
    .tmr_en_o     (tmr_en),
    .tmr_settle_o (tmr_settle),
    .rail_en_no   (rail_en_no),
    .sys_rst_no   (sys_rst_no),
    .lamp_on_o    (lamp_on_o),
    .fault_o      (fault_o)
  );

  for (genvar k = 1; k < N_RAILS; k++) begin : g_order
    a_r3_gated_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rail_en_no[k]) |-> ($past(s_pgood[k-1]) && !rail_en_no[k-1]));
  end

  a_r5_release_rails_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> (rail_en_no == '0));

  a_r6_lamp_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lamp_on_o) |-> (sys_rst_no && $past(sys_rst_no)));

  a_r6_lamp_needs_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lamp_on_o |-> sys_rst_no);

  a_r7_fault_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (&rail_en_no && !sys_rst_no && !lamp_on_o));

  a_r1_reset_safe: assert property (@(posedge clk_i)
    !rst_ni |-> (&rail_en_no && !sys_rst_no && !lamp_on_o && !fault_o));
endmodule

// File: tb/sim_pwr_seq_top.sv
`timescale 1ns/1ps
module sim_pwr_seq_top;
  localparam int NR = 3;
  localparam int NP = 2;
  localparam int TW = 16;
  localparam int SETTLE = 16;

  typedef struct packed {
    logic [7:0]  d0, d1, d2;   // 255 = rail never reports good
    logic [15:0] lim;
    logic        exp_on;
    logic [1:0]  exp_top;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'd2,   8'd2,   8'd2,   16'd20, 1'b1, 2'd2},
    '{8'd0,   8'd0,   8'd0,   16'd5,  1'b1, 2'd2},
    '{8'd12,  8'd30,  8'd5,   16'd40, 1'b1, 2'd2},
    '{8'd255, 8'd1,   8'd1,   16'd30, 1'b0, 2'd0},
    '{8'd3,   8'd255, 8'd3,   16'd25, 1'b0, 2'd1},
    '{8'd4,   8'd4,   8'd255, 16'd25, 1'b0, 2'd2},
    '{8'd60,  8'd1,   8'd1,   16'd20, 1'b0, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic on_req_ni = 1'b1;
  logic [NP-1:0] prot_ni = '1;
  logic [NR-1:0] pgood;
  logic [TW-1:0] wait_limit = 16'd20;
  logic [NR-1:0] rail_en_no;
  logic sys_rst_no, lamp_on_o, fault_o;

  int dly [NR];
  logic [NR-1:0] kill = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_seq_top #(.N_RAILS(NR), .N_PROT(NP), .TO_W(TW), .SETTLE_CYC(SETTLE)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .on_req_ni(on_req_ni), .prot_ni(prot_ni),
    .pgood_i(pgood), .wait_limit_i(wait_limit), .rail_en_no(rail_en_no),
    .sys_rst_no(sys_rst_no), .lamp_on_o(lamp_on_o), .fault_o(fault_o)
  );

  // rail model and monitor, both on the falling edge
  int rcnt [NR];
  int cyc = 0, top_en, order_err, last_fall, sys_rise, lamp_rise;
  logic [NR-1:0] en_prev;
  logic sys_prev, lamp_prev;

  always @(negedge clk) begin
    cyc++;
    for (int k = 0; k < NR; k++) begin
      if (!rst_ni || rail_en_no[k]) rcnt[k] = 0;
      else if (rcnt[k] < 1000) rcnt[k]++;
      pgood[k] = !kill[k] && (dly[k] != 255) && (rcnt[k] > dly[k]);
    end
    if (!rst_ni) begin
      top_en = -1; order_err = 0; last_fall = -1; sys_rise = -1; lamp_rise = -1;
      en_prev = '1; sys_prev = 0; lamp_prev = 0;
    end else begin
      for (int k = 0; k < NR; k++) begin
        if (en_prev[k] && !rail_en_no[k]) begin
          if (k > top_en) top_en = k;
          if (k > 0 && (rail_en_no[k-1] || !pgood[k-1])) order_err++;
          if (k == NR-1) last_fall = cyc;
        end
      end
      if (!sys_prev && sys_rst_no) sys_rise = cyc;
      if (!lamp_prev && lamp_on_o) lamp_rise = cyc;
      en_prev = rail_en_no; sys_prev = sys_rst_no; lamp_prev = lamp_on_o;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input int a, input int b, input int c, input int lim);
    rst_ni = 0; on_req_ni = 1; prot_ni = '1; kill = '0;
    dly[0] = a; dly[1] = b; dly[2] = c; wait_limit = TW'(lim);
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_until_done();
    on_req_ni = 0;
    for (int i = 0; i < 3000 && !lamp_on_o && !fault_o; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    on_req_ni = 1;
  endtask

  task automatic chk_safe(input string req);
    chk(&rail_en_no && !sys_rst_no && !lamp_on_o && fault_o, req,
        "fault safe outputs {en,rst,lamp,fault}",
        {rail_en_no, sys_rst_no, lamp_on_o, fault_o}, {3'b111, 3'b001});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    dly[0] = 1; dly[1] = 1; dly[2] = 1;
    // R1: reset state; R2: no request -> stays idle
    do_reset(1, 1, 1, 20);
    chk({rail_en_no, sys_rst_no, lamp_on_o, fault_o} == 6'b111000, "R1",
        "reset outputs", {rail_en_no, sys_rst_no, lamp_on_o, fault_o}, 6'b111000);
    repeat (50) @(negedge clk);
    chk(&rail_en_no && !sys_rst_no && !fault_o, "R2", "idle without request",
        rail_en_no, 3'b111);

    // vector table: per-rail delays and wait limits
    for (int v = 0; v < NV; v++) begin
      do_reset(VECS[v].d0, VECS[v].d1, VECS[v].d2, VECS[v].lim);
      run_until_done();
      chk(top_en == int'(VECS[v].exp_top), "R3/R4", $sformatf("vec%0d highest rail", v),
          top_en, VECS[v].exp_top);
      chk(order_err == 0, "R3", $sformatf("vec%0d enable order", v), order_err, 0);
      if (VECS[v].exp_on) begin
        chk(lamp_on_o && sys_rst_no && !fault_o && rail_en_no == '0, "R6",
            $sformatf("vec%0d on state", v), {rail_en_no, sys_rst_no, lamp_on_o, fault_o},
            6'b000110);
        chk(sys_rise - last_fall >= SETTLE + 1, "R5", $sformatf("vec%0d settle gap", v),
            sys_rise - last_fall, SETTLE + 1);
        chk(lamp_rise == sys_rise + 1, "R6", $sformatf("vec%0d lamp delay", v),
            lamp_rise - sys_rise, 1);
      end else begin
        chk_safe("R4");
        chk(sys_rise == -1, "R4", $sformatf("vec%0d no reset release", v), sys_rise, -1);
      end
    end

    // R4: timeout timing with rail 0 never good, limit 40
    do_reset(255, 1, 1, 40);
    on_req_ni = 0;
    for (int i = 0; i < 20 && rail_en_no[0]; i++) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(!fault_o, "R4", "no fault before limit", fault_o, 0);
    repeat (20) @(negedge clk);
    chk(fault_o, "R4", "fault after limit", fault_o, 1);

    // R8/R7: protection in on state
    do_reset(2, 2, 2, 20);
    run_until_done();
    prot_ni[1] = 0;
    repeat (5) @(negedge clk);
    chk_safe("R8");
    // R10: sticky through input recovery and a new request
    prot_ni = '1; on_req_ni = 0;
    repeat (50) @(negedge clk);
    chk(fault_o && &rail_en_no, "R10", "fault held", fault_o, 1);
    rst_ni = 0; @(negedge clk); rst_ni = 1; on_req_ni = 1; @(negedge clk);
    chk(!fault_o && &rail_en_no, "R10", "fault cleared by reset", fault_o, 0);

    // R9: power-good loss in on state
    do_reset(2, 2, 2, 20);
    run_until_done();
    kill[1] = 1;
    repeat (6) @(negedge clk);
    chk_safe("R9");

    // R8: protection during sequencing, before timeout
    do_reset(255, 1, 1, 500);
    on_req_ni = 0;
    repeat (10) @(negedge clk);
    prot_ni[0] = 0;
    repeat (5) @(negedge clk);
    chk_safe("R8");

    // R8/R11: protection in idle, latency through synchronizer
    do_reset(1, 1, 1, 20);
    prot_ni[0] = 0;
    repeat (2) @(negedge clk);
    chk(!fault_o, "R11", "fault not before third edge", fault_o, 0);
    @(negedge clk);
    chk(fault_o, "R11", "fault after third edge", fault_o, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule